// File: doc/BRIEF.md
# Timer-Paced FIFO Pattern Player

This block is a test-pattern source. A host first fills an internal FIFO with 9-bit words. Each word is written by pulsing a write strobe while the block is in load mode. The host then switches to send mode and raises a run input. A programmable square-wave divider paces playback. Every rising edge of its output releases one stored word onto the output data register, and the register keeps that word until the next release.

A 3-bit mode input selects the operation. Code 0 is idle, 1 is load, 2 is send and 7 clears the FIFO. Codes 3 to 6 act as idle. The divider has its own enable and a 16-bit half-period constant, so it can run freely whatever the mode. To end playback, the host drops run and polls the empty flag until the FIFO has drained. It then returns to idle and stops the divider. Two active-low enable outputs show whether the write side or the read side of the FIFO is currently open.

Top module: `pattern_player`

## Requirements
- R1: After reset, empty_o = 1, full_o = 0, data_o = 0, word_vld_o = 0 and sq_o = 0.
- R2: Mode codes are 0 = idle, 1 = load, 2 = send and 7 = clear, and codes 3 to 6 behave as idle. wr_en_n_o is 0 only in load mode. rd_en_n_o is 0 only in send mode with run_i = 1. In idle, both are 1 and the FIFO neither fills nor drains.
- R3: In load mode, each rising edge of wr_stb_i pushes data_i (bits 8:0) into the FIFO once, however long the strobe stays high.
- R4: Mode 7 empties the FIFO and clears its contents and pointers. empty_o is 1 one clock later, and none of the earlier words is ever emitted.
- R5: While timer_en_i = 1, sq_o first goes high on the first enabled clock edge and then toggles every H clocks, where H = tc_i (or 1 when tc_i = 0). When timer_en_i = 0, sq_o is 0 after the next edge.
- R6: When sq_o rises at edge E in send mode with run_i = 1 and the FIFO not empty, one word is popped at edge E+1. data_o takes the word and word_vld_o is 1 for that one cycle. At all other times data_o holds its value.
- R7: Words are emitted in the order they were pushed.
- R8: In send mode with run_i = 0, no word is popped.
- R9: Pop requests on an empty FIFO are ignored: word_vld_o stays 0 and data_o keeps its value.
- R10: full_o is 1 when DEPTH words are stored, and pushes while full are discarded.
- R11: Leaving send mode stops pops from the next clock, and no further word is emitted.
- R12: empty_o rises in the cycle in which the last stored word appears on data_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Operation code |
| wr_stb_i | input | 1 | Load strobe, acts on its rising edge |
| data_i | input | 9 | Word to load |
| run_i | input | 1 | Playback gate in send mode |
| timer_en_i | input | 1 | Divider enable |
| tc_i | input | 16 | Divider half-period in clocks |
| data_o | output | 9 | Last word emitted |
| word_vld_o | output | 1 | One-cycle pulse when data_o is updated |
| sq_o | output | 1 | Divider square wave |
| empty_o | output | 1 | FIFO holds no word |
| full_o | output | 1 | FIFO holds DEPTH words |
| wr_en_n_o | output | 1 | Write side open, active low |
| rd_en_n_o | output | 1 | Read side open, active low |

## Verification
A push, a clear or a mode change shows on empty_o, full_o and the enable outputs one clock after the edge where it was applied. sq_o shows its new level in the same cycle as the enabled edge that changes it. A released word appears on data_o one clock after the sq_o rise. The bench drives its inputs on falling edges and samples on falling edges. It compares the number of cycles between word_vld_o pulses against 2·H, and compares the sq_o level at each enabled edge against a model of the phase. Idle, run-low and post-send intervals are observed over windows several periods long, so that a stray pop would be seen.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int unsigned DATA_W = 9;
  typedef enum logic [2:0] {
    MODE_IDLE  = 3'd0,
    MODE_LOAD  = 3'd1,
    MODE_SEND  = 3'd2,
    MODE_CLEAR = 3'd7
  } pp_mode_e;
endpackage

// File: rtl/pp_fifo.sv
module pp_fifo #(
  parameter int unsigned W     = 9,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_C  = AW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == DEPTH_C);
  assign do_push = push_i && !full_o && !clr_i;
  assign do_pop  = pop_i && !empty_o && !clr_i;
  assign rdata_o = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_ptr_q] <= wdata_i;
        wr_ptr_q <= (wr_ptr_q == LAST_C) ? '0 : wr_ptr_q + 1'b1;
      end
      if (do_pop) rd_ptr_q <= (rd_ptr_q == LAST_C) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R10
  drop_when_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !clr_i) |=> full_o);
  // R9
  ignore_empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i && !clr_i) |=> empty_o);
  // R4
  clear_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> empty_o);
endmodule

// File: rtl/pp_timer.sv
module pp_timer #(
  parameter int unsigned TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [TW-1:0] tc_i,
  output logic          sq_o,
  output logic          rise_o
);
  logic [TW-1:0] cnt_q, half;

  assign half = (tc_i == '0) ? TW'(1) : tc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sq_o   <= 1'b0;
      rise_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      sq_o   <= 1'b0;
      rise_o <= 1'b0;
    end else if (cnt_q == '0) begin
      cnt_q  <= half - 1'b1;
      sq_o   <= ~sq_o;
      rise_o <= ~sq_o;
    end else begin
      cnt_q  <= cnt_q - 1'b1;
      rise_o <= 1'b0;
    end
  end

  // R5
  rise_marks_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> (sq_o && !$past(sq_o)));
  // R5
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !sq_o);
endmodule

// File: rtl/pattern_player.sv
module pattern_player
  import pp_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned TW    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic              wr_stb_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              run_i,
  input  logic              timer_en_i,
  input  logic [TW-1:0]     tc_i,
  output logic [DATA_W-1:0] data_o,
  output logic              word_vld_o,
  output logic              sq_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              wr_en_n_o,
  output logic              rd_en_n_o
);
  logic              is_load, is_send, is_clr;
  logic              stb_q, push, pop, tick;
  logic [DATA_W-1:0] head;

  assign is_load   = (mode_i == MODE_LOAD);
  assign is_send   = (mode_i == MODE_SEND);
  assign is_clr    = (mode_i == MODE_CLEAR);
  assign wr_en_n_o = !is_load;
  assign rd_en_n_o = !(is_send && run_i);
  assign push      = is_load && wr_stb_i && !stb_q;
  assign pop       = is_send && run_i && tick;

  pp_timer #(.TW(TW)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (timer_en_i),
    .tc_i  (tc_i),
    .sq_o  (sq_o),
    .rise_o(tick)
  );

  pp_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (is_clr),
    .push_i (push),
    .pop_i  (pop),
    .wdata_i(data_i),
    .rdata_o(head),
    .empty_o(empty_o),
    .full_o (full_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q      <= 1'b0;
      data_o     <= '0;
      word_vld_o <= 1'b0;
    end else begin
      stb_q      <= wr_stb_i;
      word_vld_o <= pop && !empty_o;
      if (pop && !empty_o) data_o <= head;
    end
  end

  // R6
  vld_follows_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |-> $past(tick));
  // R11
  vld_needs_send_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |-> ($past(mode_i) == MODE_SEND && $past(run_i)));
  // R6
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_vld_o |-> $stable(data_o));
endmodule

// File: tb/pattern_player_test.sv
module pattern_player_test;
  localparam int DEPTH = 8;
  logic clk = 0, rst_n = 0;
  logic [2:0] mode = 0;
  logic stb = 0, run = 0, ten = 0;
  logic [8:0] din = 0;
  logic [15:0] tc = 0;
  logic [8:0] dout;
  logic vld, sq, empty, full, wen_n, ren_n;
  int n_chk = 0, n_fail = 0;
  logic [8:0] got [32];
  int got_t [32];
  int n_got;

  always #5 clk = ~clk;

  pattern_player #(.DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .wr_stb_i(stb), .data_i(din),
    .run_i(run), .timer_en_i(ten), .tc_i(tc), .data_o(dout), .word_vld_o(vld),
    .sq_o(sq), .empty_o(empty), .full_o(full), .wr_en_n_o(wen_n), .rd_en_n_o(ren_n));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_word(input logic [8:0] w);
    @(negedge clk); din = w; stb = 1;
    @(negedge clk); stb = 0;
  endtask

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk); mode = m;
  endtask

  task automatic collect(input int cycles);
    n_got = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (vld && n_got < 32) begin got[n_got] = dout; got_t[n_got] = c; n_got++; end
    end
  endtask

  task automatic start_send(input logic [15:0] t, input logic r);
    @(negedge clk); mode = 3'd2; run = r; tc = t; ten = 1;
  endtask

  task automatic stop_all();
    @(negedge clk); ten = 0; run = 0; mode = 3'd7;
    @(negedge clk); mode = 3'd0;
  endtask

  task automatic t_reset();
    chk(empty && !full && dout == 0 && !vld && !sq, "R1 reset state", {empty, full, vld, sq}, 4'b1000);
    chk(wen_n && ren_n, "R2 idle enables", {wen_n, ren_n}, 2'b11);
  endtask

  task automatic t_idle();
    set_mode(3'd0);
    push_word(9'h055);
    @(negedge clk);
    chk(empty, "R2 idle strobe ignored", empty, 1);
    set_mode(3'd5);
    push_word(9'h055);
    @(negedge clk);
    chk(empty && wen_n && ren_n, "R2 code 5 acts idle", {empty, wen_n, ren_n}, 3'b111);
    set_mode(3'd1);
    @(negedge clk);
    chk(!wen_n, "R2 load opens write", wen_n, 0);
  endtask

  task automatic t_play();
    set_mode(3'd1);
    for (int i = 0; i < 5; i++) push_word(9'(9'h100 + i * 7));
    chk(!empty, "R3 words loaded", empty, 0);
    start_send(16'd2, 1);
    @(negedge clk);
    chk(!ren_n, "R2 send run opens read", ren_n, 0);
    collect(40);
    chk(n_got == 5, "R6 word count", n_got, 5);
    for (int i = 0; i < 5 && i < n_got; i++)
      chk(got[i] == 9'(9'h100 + i * 7), "R7 order", got[i], 9'h100 + i * 7);
    for (int i = 1; i < n_got; i++)
      chk(got_t[i] - got_t[i-1] == 4, "R6 spacing 2H", got_t[i] - got_t[i-1], 4);
    chk(empty, "R12 drained", empty, 1);
    chk(dout == 9'(9'h100 + 28), "R9 data held on empty", dout, 9'h100 + 28);
    stop_all();
  endtask

  task automatic t_last_empty();
    set_mode(3'd1);
    push_word(9'h0aa);
    start_send(16'd3, 1);
    n_got = 0;
    for (int c = 0; c < 30 && n_got == 0; c++) begin
      @(negedge clk);
      if (vld) begin
        n_got = 1;
        chk(empty && dout == 9'h0aa, "R12 empty with last word", {empty, dout}, {1'b1, 9'h0aa});
      end
    end
    chk(n_got == 1, "R12 word seen", n_got, 1);
    stop_all();
  endtask

  task automatic t_strobe_hold();
    set_mode(3'd1);
    @(negedge clk); din = 9'h1f0; stb = 1;
    repeat (3) @(negedge clk);
    stb = 0;
    start_send(16'd1, 1);
    collect(20);
    chk(n_got == 1, "R3 held strobe pushes once", n_got, 1);
    stop_all();
  endtask

  task automatic t_clear();
    set_mode(3'd1);
    for (int i = 0; i < 3; i++) push_word(9'(i + 1));
    set_mode(3'd7);
    @(negedge clk);
    chk(empty, "R4 clear empties", empty, 0 + 1);
    start_send(16'd1, 1);
    collect(20);
    chk(n_got == 0, "R4 no old words", n_got, 0);
    stop_all();
  endtask

  task automatic t_full();
    set_mode(3'd1);
    for (int i = 0; i < DEPTH + 2; i++) push_word(9'(i + 9'h40));
    chk(full, "R10 full flag", full, 1);
    start_send(16'd1, 1);
    collect(60);
    chk(n_got == DEPTH, "R10 extra pushes dropped", n_got, DEPTH);
    chk(got[DEPTH-1] == 9'(DEPTH - 1 + 9'h40), "R10 last kept word", got[DEPTH-1], DEPTH - 1 + 'h40);
    stop_all();
  endtask

  task automatic t_run_gate();
    set_mode(3'd1);
    push_word(9'h011); push_word(9'h022);
    start_send(16'd2, 0);
    collect(40);
    chk(n_got == 0 && !empty, "R8 run low holds", n_got, 0);
    @(negedge clk); run = 1;
    collect(40);
    chk(n_got == 2 && got[0] == 9'h011, "R8 run high releases", n_got, 2);
    stop_all();
  endtask

  task automatic t_leave_send();
    set_mode(3'd1);
    for (int i = 0; i < 4; i++) push_word(9'(9'h080 + i));
    start_send(16'd3, 1);
    n_got = 0;
    for (int c = 0; c < 40 && n_got == 0; c++) begin
      @(negedge clk);
      if (vld) n_got = 1;
    end
    mode = 3'd0;
    collect(40);
    chk(n_got == 0, "R11 no pop after send", n_got, 0);
    chk(!empty && dout == 9'h080, "R11 remaining kept", dout, 9'h080);
    stop_all();
  endtask

  task automatic t_timer();
    int h;
    for (int k = 0; k < 2; k++) begin
      h = (k == 0) ? 1 : 5;
      @(negedge clk); tc = (k == 0) ? 16'd0 : 16'd5; ten = 1;
      for (int e = 0; e < 4 * h; e++) begin
        @(negedge clk);
        chk(sq == (((e / h) % 2) == 0), "R5 square phase", sq, ((e / h) % 2) == 0);
      end
      @(negedge clk); ten = 0;
      @(negedge clk);
      chk(!sq, "R5 disabled low", sq, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_idle();
    stop_all();
    t_play();
    t_last_empty();
    t_strobe_hold();
    t_clear();
    t_full();
    t_run_gate();
    t_leave_send();
    t_timer();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule